// File: doc/BRIEF.md
# Operand Decode Stage with Branch Target Adder

This block is the operand-preparation stage of a single-cycle processor core. From the current instruction word it reads two source operands out of a sixteen-entry register file. It also produces an extended immediate and a branch target address. The branch target is formed by a dedicated adder inside this stage, so the ALU is never used for it. The register file holds no program-counter entry. The incremented fetch address (the address of the current instruction plus eight) arrives as an input instead.

The register file has two combinational read ports and one write port, which is fed from the write-back path and written on the clock edge. All outputs are combinational functions of the instruction, the fetch address input and the stored registers. The stage holds no pipeline state of its own, so it has no handshake and never applies back-pressure. An instruction presented in a cycle is fully decoded within that same cycle. The instruction class is taken from bits [27:26]: 00 is data processing, 01 is load/store, 10 is branch and 11 is any other instruction.

Top module: `dec_stage`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero. After reset is released, both source outputs read zero for any index until that register is written.
- R2: `src_a` always equals the register selected by `instr[19:16]`, and `src_b` always equals the register selected by `instr[3:0]`. Both are combinational, with no clock delay.
- R3: When `wb_en` is 1 at a rising clock edge, `wb_data` is stored into register `wb_addr`. The new value is visible on the read ports after that edge and not before it.
- R4: When `wb_en` is 0 at a rising clock edge, no register changes.
- R5: A write aimed at index 15 is discarded. Register 15 always reads zero.
- R6: For class 00, `imm_ext` is `instr[7:0]` zero-extended to 32 bits.
- R7: For class 01, `imm_ext` is `instr[11:0]` zero-extended to 32 bits.
- R8: For class 10, `imm_ext` is `instr[23:0]` sign-extended to 32 bits. For class 11, `imm_ext` is zero.
- R9: For every instruction, `br_target` equals `pc_plus8` plus four times the sign-extended `instr[23:0]`, taken modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register write occurs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| instr | input | 32 | Instruction word being decoded |
| pc_plus8 | input | 32 | Address of the current instruction plus eight |
| wb_en | input | 1 | Write-back enable |
| wb_addr | input | 4 | Write-back destination register index |
| wb_data | input | 32 | Write-back value |
| src_a | output | 32 | First source operand, register selected by instr[19:16] |
| src_b | output | 32 | Second source operand, register selected by instr[3:0] |
| imm_ext | output | 32 | Extended immediate, chosen by instruction class |
| br_target | output | 32 | Branch target address |

## Verification
The assertions assume that `wb_en`, `wb_addr` and `wb_data` are known and settled at each rising edge. They also assume that `instr` and `pc_plus8` are stable around the sampling point, because all checks are sampled on that clock. The bench keeps to these conditions by changing every input only on the falling edge. It samples outputs one time unit after a falling edge, so each comparison sees the registered state after the most recent rising edge, together with the combinational outputs for the current inputs.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 16;
  localparam int OFF_W = 24;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_MEM    = 2'b01,
    CLS_BRANCH = 2'b10,
    CLS_OTHER  = 2'b11
  } insn_class_e;

  function automatic insn_class_e class_of(input logic [31:0] word);
    return insn_class_e'(word[27:26]);
  endfunction
endpackage

// File: rtl/dec_regfile.sv
module dec_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 16,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);
  localparam logic [AW-1:0] LOCKED_IDX = AW'(NREGS - 1);

  logic [XLEN-1:0] regs [NREGS];
  logic            wr_ok;

  assign wr_ok = we && (waddr != LOCKED_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != LOCKED_IDX) |=> regs[$past(waddr)] == $past(wdata)); // R3

  AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regs[NREGS-1] == '0); // R5

  AST_CLEAR_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rdata_a == '0 && rdata_b == '0)); // R1

  for (genvar g = 0; g < NREGS; g++) begin : g_hold
    AST_ENTRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == AW'(g)) |=> $stable(regs[g])); // R4
  end
endmodule

// File: rtl/dec_imm_ext.sv
module dec_imm_ext
  import dec_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ALU_W  = 8,
  parameter int MEM_W  = 12,
  parameter int OFF_W  = 24
) (
  input  logic [31:0]     instr,
  output logic [XLEN-1:0] imm
);
  insn_class_e cls;
  assign cls = class_of(instr);

  always_comb begin
    unique case (cls)
      CLS_ALU:    imm = XLEN'(instr[ALU_W-1:0]);
      CLS_MEM:    imm = XLEN'(instr[MEM_W-1:0]);
      CLS_BRANCH: imm = {{(XLEN-OFF_W){instr[OFF_W-1]}}, instr[OFF_W-1:0]};
      default:    imm = '0;
    endcase
  end
endmodule

// File: rtl/dec_branch_adder.sv
module dec_branch_adder #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 24,
  parameter int SHIFT = 2
) (
  input  logic [XLEN-1:0]  pc_plus8,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target
);
  logic [XLEN-1:0] off_sx;
  logic [XLEN-1:0] off_scaled;

  assign off_sx     = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
  assign off_scaled = off_sx << SHIFT;
  assign target     = pc_plus8 + off_scaled;
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr,
  input  logic [31:0] pc_plus8,
  input  logic        wb_en,
  input  logic [3:0]  wb_addr,
  input  logic [31:0] wb_data,
  output logic [31:0] src_a,
  output logic [31:0] src_b,
  output logic [31:0] imm_ext,
  output logic [31:0] br_target
);
  localparam int AW = $clog2(NREGS);

  logic [AW-1:0] idx_n;
  logic [AW-1:0] idx_m;

  assign idx_n = instr[19:16];
  assign idx_m = instr[3:0];

  dec_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wb_en),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (idx_n),
    .raddr_b (idx_m),
    .rdata_a (src_a),
    .rdata_b (src_b)
  );

  dec_imm_ext #(.XLEN(XLEN), .OFF_W(OFF_W)) u_imm (
    .instr (instr),
    .imm   (imm_ext)
  );

  dec_branch_adder #(.XLEN(XLEN), .OFF_W(OFF_W)) u_bta (
    .pc_plus8 (pc_plus8),
    .offset   (instr[OFF_W-1:0]),
    .target   (br_target)
  );

  AST_ALU_IMM_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[27:26] == 2'b00) |-> (imm_ext[31:8] == '0)); // R6

  AST_MEM_IMM_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[27:26] == 2'b01) |-> (imm_ext[31:12] == '0)); // R7

  AST_OTHER_IMM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[27:26] == 2'b11) |-> (imm_ext == '0)); // R8

  AST_BR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    br_target[1:0] == pc_plus8[1:0]); // R9
endmodule

// File: tb/tb_dec_stage.sv
module tb_dec_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc_plus8 = '0;
  logic        wb_en = 1'b0;
  logic [3:0]  wb_addr = '0;
  logic [31:0] wb_data = '0;
  logic [31:0] src_a, src_b, imm_ext, br_target;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dec_stage dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc_plus8(pc_plus8),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .src_a(src_a), .src_b(src_b), .imm_ext(imm_ext), .br_target(br_target)
  );

  // {instr, pc_plus8, expected imm_ext, expected br_target}
  localparam logic [127:0] VEC [6] = '{
    {32'h0000_12A5, 32'h0000_0100, 32'h0000_00A5, 32'h0000_4B94},
    {32'h0500_0FFF, 32'h0000_0020, 32'h0000_0FFF, 32'h0000_401C},
    {32'h0AFF_FFFE, 32'h0000_1008, 32'hFFFF_FFFE, 32'h0000_1000},
    {32'h0A80_0000, 32'h0200_0008, 32'hFF80_0000, 32'h0000_0008},
    {32'h0E00_1234, 32'h0000_0008, 32'h0000_0000, 32'h0000_48D8},
    {32'h087F_FFFF, 32'hFFFF_FFF8, 32'h007F_FFFF, 32'h01FF_FFF4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic en, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wb_en = en; wb_addr = a; wb_data = d;
    @(negedge clk);
    wb_en = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] rd_word(input logic [3:0] n, input logic [3:0] m);
    return {12'h0, n, 12'h0, m};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    instr = rd_word(4'd2, 4'd9);
    #1;
    chk("R1 reset src_a", src_a, 32'h0);
    chk("R1 reset src_b", src_b, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: immediate and branch target per class
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      instr = VEC[k][127:96];
      pc_plus8 = VEC[k][95:64];
      #1;
      case (VEC[k][123:122])
        2'b00:   chk("R6 alu imm", imm_ext, VEC[k][63:32]);
        2'b01:   chk("R7 mem imm", imm_ext, VEC[k][63:32]);
        default: chk("R8 branch/other imm", imm_ext, VEC[k][63:32]);
      endcase
      chk("R9 branch target", br_target, VEC[k][31:0]);
    end

    // R3 and R2: fill registers 0..14 and read them on both ports
    for (int i = 0; i < 15; i++) wr(1'b1, 4'(i), 32'hA500_0000 + 32'(i) * 32'h0101);
    for (int i = 0; i < 15; i++) begin
      instr = rd_word(4'(i), 4'(14 - i));
      #1;
      chk("R2 src_a read", src_a, 32'hA500_0000 + 32'(i) * 32'h0101);
      chk("R2 src_b read", src_b, 32'hA500_0000 + 32'(14 - i) * 32'h0101);
    end

    // R3: value not visible before the edge, visible after
    instr = rd_word(4'd7, 4'd7);
    @(negedge clk);
    wb_en = 1'b1; wb_addr = 4'd7; wb_data = 32'hDEAD_BEEF;
    #1;
    chk("R3 before edge", src_a, 32'hA500_0000 + 32'd7 * 32'h0101);
    @(negedge clk);
    wb_en = 1'b0;
    #1;
    chk("R3 after edge", src_b, 32'hDEAD_BEEF);

    // R4: disabled write leaves register alone
    wr(1'b0, 4'd7, 32'h1234_5678);
    chk("R4 disabled write", src_a, 32'hDEAD_BEEF);

    // R5: write to index 15 is dropped
    wr(1'b1, 4'd15, 32'hFFFF_0000);
    instr = rd_word(4'd15, 4'd15);
    #1;
    chk("R5 locked src_a", src_a, 32'h0);
    chk("R5 locked src_b", src_b, 32'h0);

    // R1: reset clears previously written registers
    @(negedge clk);
    rst_n = 1'b0;
    instr = rd_word(4'd7, 4'd3);
    #1;
    chk("R1 reset clears src_a", src_a, 32'h0);
    chk("R1 reset clears src_b", src_b, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 zero after release", src_a, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule